// File: doc/BRIEF.md
# Multi-Mode Integer Lane ALU

This block is the arithmetic heart of one lane of an outer-product accumulator. On each accepted request it takes an x element, a y element and an accumulator value z. A mode code and a 5-bit shift amount then choose how the three combine, and the new accumulator value appears one cycle later. The supported operations are these:

- a multiply-accumulate with an arithmetic right shift of the product;
- an add-accumulate with a right shift of the sum;
- subtracting forms of both;
- a rounding, doubling multiply-high that saturates to the signed 16-bit range;
- an XNOR-popcount accumulate for binary networks.

Operand and accumulator widths are picked per request from 8, 16 and 32 bits. The x and y operands are each sign-extended or zero-extended according to their own flag. All internal arithmetic runs on a 2·DW+2 bit signed datapath, so no product or sum wraps before it is shifted. The result is truncated to the accumulator width.

Control is a two-state machine. In state `ST_IDLE` no result is presented. A cycle with `in_valid` high moves it to `ST_OUT` (transition *accept*). In `ST_OUT` the result register is presented with `out_valid`. Another `in_valid` keeps it in `ST_OUT` and loads the next result (transition *stream*). A cycle without `in_valid` returns it to `ST_IDLE` (transition *drain*). Reset forces `ST_IDLE`.

Top module: `lane_alu`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `result` is 0 from the next clock edge on.
- R2: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. `result` changes only on an edge where `in_valid` is high.
- R3: Modes 0 and 8 return z + (x·y >>> s), where s is `shamt`.
- R4: Mode 1 returns z − (x·y >>> s). The shifted term is negated, then added.
- R5: Mode 2 returns z + ((x+y) >>> s), and mode 3 returns z − ((x+y) >>> s).
- R6: Modes 5 and 6 treat x, y and z as 16-bit values regardless of the width selects, and ignore `shamt`. They form (x·y + 2^14) >>> 15, add it to z (mode 5) or subtract it (mode 6), and clamp the sum to [−32768, 32767]. The 16-bit result appears in `result[15:0]`, with the upper bits zero.
- R7: Mode 9 returns z plus the number of bit positions below the operand width where x and y agree. `shamt` is ignored.
- R8: Modes 4, 7 and 10 to 63 return z unchanged, truncated to the z width.
- R9: Width code 0 selects 8 bits, code 1 selects 16 bits, and codes 2 and 3 select 32 bits. The x and y operands are sign-extended when their flag is 1 and zero-extended when it is 0. z is always sign-extended. Right shifts are arithmetic on the extended values.
- R10: `result` holds the low z-width bits of the computed value, and the bits above the z width are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request accepted this cycle |
| mode | input | 6 | Operation code |
| shamt | input | 5 | Right-shift amount |
| x_signed | input | 1 | x is signed when 1 |
| y_signed | input | 1 | y is signed when 1 |
| op_wsel | input | 2 | x/y width code |
| z_wsel | input | 2 | z width code |
| x_in | input | DW | x operand |
| y_in | input | DW | y operand |
| z_in | input | DW | Accumulator input |
| out_valid | output | 1 | Result valid |
| result | output | DW | New accumulator value |

## Verification
A bad state bit would show within one cycle as an `out_valid` that fails to track the previous cycle's `in_valid`, or as a `result` that moves without a request. A fault in the extension, shift, negation, rounding or clamp logic corrupts the very next result. The bench therefore compares every output cycle against an arithmetic model over sweeps that cover:

- every mode code from 0 to 15;
- all three width codes for operands and accumulator;
- all four signedness pairings;
- edge operand values.

Directed cases probe both saturation limits.

// File: rtl/lane_alu_pkg.sv
package lane_alu_pkg;

    typedef enum logic {
        ST_IDLE,
        ST_OUT
    } state_t;

    localparam logic [5:0] M_MAC  = 6'd0;
    localparam logic [5:0] M_MSB  = 6'd1;
    localparam logic [5:0] M_ADD  = 6'd2;
    localparam logic [5:0] M_SUB  = 6'd3;
    localparam logic [5:0] M_QADD = 6'd5;
    localparam logic [5:0] M_QSUB = 6'd6;
    localparam logic [5:0] M_MAC8 = 6'd8;
    localparam logic [5:0] M_XNOR = 6'd9;

    function automatic int width_bits(input logic [1:0] code);
        case (code)
            2'd0:    return 8;
            2'd1:    return 16;
            default: return 32;
        endcase
    endfunction

endpackage

// File: rtl/lane_alu_extend.sv
module lane_alu_extend
    import lane_alu_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 2 * DW + 2
) (
    input  logic [DW-1:0]        raw,
    input  logic [1:0]           wsel,
    input  logic                 sgn,
    output logic signed [AW-1:0] ext
);

    int   nb;
    logic msb;

    always_comb begin
        nb = width_bits(wsel);
        case (wsel)
            2'd0:    msb = raw[7];
            2'd1:    msb = raw[15];
            default: msb = raw[DW-1];
        endcase
        for (int i = 0; i < AW; i++) begin
            if (i < nb && i < DW) ext[i] = raw[i];
            else                  ext[i] = sgn & msb;
        end
    end

endmodule

// File: rtl/lane_alu_popcnt.sv
module lane_alu_popcnt
    import lane_alu_pkg::*;
#(
    parameter int DW = 32,
    localparam int CW = $clog2(DW + 1)
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic [1:0]    wsel,
    output logic [CW-1:0] count
);

    int nb;

    always_comb begin
        nb    = width_bits(wsel);
        count = '0;
        for (int i = 0; i < DW; i++) begin
            if (i < nb && a[i] == b[i]) count = count + CW'(1);
        end
    end

endmodule

// File: rtl/lane_alu_core.sv
module lane_alu_core
    import lane_alu_pkg::*;
#(
    parameter int DW = 32,
    localparam int AW = 2 * DW + 2,
    localparam int CW = $clog2(DW + 1)
) (
    input  logic [5:0]    mode,
    input  logic [4:0]    shamt,
    input  logic          x_signed,
    input  logic          y_signed,
    input  logic [1:0]    op_wsel,
    input  logic [1:0]    z_wsel,
    input  logic [DW-1:0] x_in,
    input  logic [DW-1:0] y_in,
    input  logic [DW-1:0] z_in,
    output logic [DW-1:0] value
);

    localparam logic signed [AW-1:0] RND    = {{(AW-15){1'b0}}, 1'b1, 14'b0};
    localparam logic signed [AW-1:0] SAT_HI = {{(AW-15){1'b0}}, {15{1'b1}}};
    localparam logic signed [AW-1:0] SAT_LO = {{(AW-15){1'b1}}, 15'b0};

    logic                 q15;
    logic [1:0]           ow_eff, zw_eff;
    logic signed [AW-1:0] xe, ye, ze;
    logic [CW-1:0]        agree;
    logic signed [AW-1:0] prod, sum, term, acc;
    logic                 neg, noop;
    logic [DW-1:0]        zmask;
    int                   zb;

    assign q15    = (mode == M_QADD) || (mode == M_QSUB);
    assign ow_eff = q15 ? 2'd1 : op_wsel;
    assign zw_eff = q15 ? 2'd1 : z_wsel;

    lane_alu_extend #(.DW(DW), .AW(AW)) u_xext (.raw(x_in), .wsel(ow_eff), .sgn(x_signed), .ext(xe));
    lane_alu_extend #(.DW(DW), .AW(AW)) u_yext (.raw(y_in), .wsel(ow_eff), .sgn(y_signed), .ext(ye));
    lane_alu_extend #(.DW(DW), .AW(AW)) u_zext (.raw(z_in), .wsel(zw_eff), .sgn(1'b1),     .ext(ze));

    lane_alu_popcnt #(.DW(DW)) u_pop (.a(x_in), .b(y_in), .wsel(ow_eff), .count(agree));

    assign prod = xe * ye;
    assign sum  = xe + ye;

    always_comb begin
        term = '0;
        neg  = 1'b0;
        noop = 1'b0;
        case (mode)
            M_MAC, M_MAC8: term = prod >>> shamt;
            M_MSB: begin
                term = prod >>> shamt;
                neg  = 1'b1;
            end
            M_ADD: term = sum >>> shamt;
            M_SUB: begin
                term = sum >>> shamt;
                neg  = 1'b1;
            end
            M_QADD: term = (prod + RND) >>> 15;
            M_QSUB: begin
                term = (prod + RND) >>> 15;
                neg  = 1'b1;
            end
            M_XNOR: term[CW-1:0] = agree;
            default: noop = 1'b1;
        endcase

        if (noop)     acc = ze;
        else if (neg) acc = ze - term;
        else          acc = ze + term;

        if (q15) begin
            if (acc > SAT_HI)      acc = SAT_HI;
            else if (acc < SAT_LO) acc = SAT_LO;
        end

        zb = width_bits(zw_eff);
        for (int i = 0; i < DW; i++) zmask[i] = (i < zb);
        value = acc[DW-1:0] & zmask;
    end

endmodule

// File: rtl/lane_alu.sv
module lane_alu
    import lane_alu_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [5:0]    mode,
    input  logic [4:0]    shamt,
    input  logic          x_signed,
    input  logic          y_signed,
    input  logic [1:0]    op_wsel,
    input  logic [1:0]    z_wsel,
    input  logic [DW-1:0] x_in,
    input  logic [DW-1:0] y_in,
    input  logic [DW-1:0] z_in,
    output logic          out_valid,
    output logic [DW-1:0] result
);

    state_t        state_q, state_d;
    logic [DW-1:0] value;

    lane_alu_core #(.DW(DW)) u_core (
        .mode     (mode),
        .shamt    (shamt),
        .x_signed (x_signed),
        .y_signed (y_signed),
        .op_wsel  (op_wsel),
        .z_wsel   (z_wsel),
        .x_in     (x_in),
        .y_in     (y_in),
        .z_in     (z_in),
        .value    (value)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (in_valid)  state_d = ST_OUT;
            ST_OUT:  if (!in_valid) state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        result <= '0;
        else if (in_valid) result <= value;
    end

    always_comb out_valid = (state_q == ST_OUT);

endmodule

// File: rtl/lane_alu_chk.sv
module lane_alu_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [5:0]    mode,
    input logic [1:0]    z_wsel,
    input logic [DW-1:0] z_in,
    input logic          out_valid,
    input logic [DW-1:0] result
);

    // R1
    rst_idle_chk: assert property (@(posedge clk) !rst_n |=> (!out_valid && result == '0));

    // R2
    vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid);

    // R2
    vld_drop_chk: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid);

    // R2
    res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> $stable(result));

    // R10
    z8_trunc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && z_wsel == 2'd0 && mode != 6'd5 && mode != 6'd6) |=> result[DW-1:8] == '0);

    // R6
    q15_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (mode == 6'd5 || mode == 6'd6)) |=> result[DW-1:16] == '0);

    // R8
    noop_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 6'd7 && z_wsel == 2'd2) |=> result == $past(z_in));

endmodule

bind lane_alu lane_alu_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .mode      (mode),
    .z_wsel    (z_wsel),
    .z_in      (z_in),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/lane_alu_tb.sv
module lane_alu_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [5:0]    mode = '0;
    logic [4:0]    shamt = '0;
    logic          x_signed = 1'b0, y_signed = 1'b0;
    logic [1:0]    op_wsel = '0, z_wsel = '0;
    logic [DW-1:0] x_in = '0, y_in = '0, z_in = '0;
    logic          out_valid;
    logic [DW-1:0] result;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lane_alu #(.DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode), .shamt(shamt),
        .x_signed(x_signed), .y_signed(y_signed), .op_wsel(op_wsel), .z_wsel(z_wsel),
        .x_in(x_in), .y_in(y_in), .z_in(z_in), .out_valid(out_valid), .result(result)
    );

    function automatic int wb(input int code);
        return (code == 0) ? 8 : (code == 1) ? 16 : 32;
    endfunction

    function automatic logic signed [127:0] bext(input logic [31:0] v, input int nb, input bit sg);
        logic signed [127:0] r;
        for (int i = 0; i < 128; i++) r[i] = (i < nb) ? v[i] : (sg & v[nb-1]);
        return r;
    endfunction

    function automatic logic [31:0] model(input int md, input int s, input logic [31:0] x,
                                          input logic [31:0] y, input logic [31:0] z,
                                          input bit xs, input bit ys, input int owc, input int zwc);
        int ow, zw, cnt;
        logic signed [127:0] xv, yv, zv, t, a;
        logic [31:0] r;
        ow = wb(owc);
        zw = wb(zwc);
        if (md == 5 || md == 6) begin ow = 16; zw = 16; end
        xv = bext(x, ow, xs);
        yv = bext(y, ow, ys);
        zv = bext(z, zw, 1'b1);
        case (md)
            0, 8: a = zv + ((xv * yv) >>> s);
            1:    a = zv - ((xv * yv) >>> s);
            2:    a = zv + ((xv + yv) >>> s);
            3:    a = zv - ((xv + yv) >>> s);
            5, 6: begin
                t = (xv * yv + 128'sd16384) >>> 15;
                a = (md == 5) ? zv + t : zv - t;
                if (a > 128'sd32767)  a = 128'sd32767;
                if (a < -128'sd32768) a = -128'sd32768;
            end
            9: begin
                cnt = 0;
                for (int i = 0; i < ow; i++) if (x[i] == y[i]) cnt++;
                a = zv + 128'(cnt);
            end
            default: a = zv;
        endcase
        r = a[31:0];
        if (zw < 32) r = r & ((32'h1 << zw) - 32'h1);
        return r;
    endfunction

    function automatic string tag_of(input int md);
        case (md)
            0, 8:    return "R3 R9 R10";
            1:       return "R4 R9 R10";
            2, 3:    return "R5 R9 R10";
            5, 6:    return "R6 R9 R10";
            9:       return "R7 R9 R10";
            default: return "R8 R9 R10";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive at a falling edge, capture at the rising edge, sample at the next falling edge.
    task automatic run_op(input int md, input int s, input logic [31:0] x, input logic [31:0] y,
                          input logic [31:0] z, input bit xs, input bit ys, input int owc, input int zwc);
        in_valid = 1'b1; mode = 6'(md); shamt = 5'(s);
        x_in = x; y_in = y; z_in = z;
        x_signed = xs; y_signed = ys; op_wsel = 2'(owc); z_wsel = 2'(zwc);
        @(posedge clk);
        @(negedge clk);
        check("R2 out_valid", {31'b0, out_valid}, 32'd1);
        check(tag_of(md), result, model(md, s, x, y, z, xs, ys, owc, zwc));
    endtask

    logic [31:0] vals [6];
    int shs [3];

    initial begin
        vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0001; vals[2] = 32'hFFFF_FFFF;
        vals[3] = 32'h0000_7FFF; vals[4] = 32'h8000_8080; vals[5] = 32'h1234_5678;
        shs[0] = 0; shs[1] = 5; shs[2] = 31;

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1 out_valid", {31'b0, out_valid}, 32'd0);
        check("R1 result", result, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 idle", {31'b0, out_valid}, 32'd0);

        // R6: saturation limits
        run_op(5, 0, 32'h8000, 32'h8000, 32'h7FFF, 1, 1, 2, 2);
        check("R6 high clamp", result, 32'h0000_7FFF);
        run_op(6, 0, 32'h8000, 32'h8000, 32'h8000, 1, 1, 2, 2);
        check("R6 low clamp", result, 32'h0000_8000);
        // R7: all 8 bits agree plus z
        run_op(9, 7, 32'hA5, 32'hA5, 32'h3, 0, 0, 0, 2);
        check("R7 popcount", result, 32'd11);

        // R2: result holds with no request
        in_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R2 drain", {31'b0, out_valid}, 32'd0);
        check("R2 hold", result, 32'd11);

        for (int md = 0; md < 16; md++)
            for (int owc = 0; owc < 3; owc++)
                for (int zwc = 0; zwc < 3; zwc++)
                    for (int sg = 0; sg < 4; sg++)
                        for (int i = 0; i < 6; i++)
                            for (int j = 0; j < 6; j++)
                                for (int k = 0; k < 3; k++)
                                    run_op(md, shs[k], vals[i], vals[j],
                                           vals[(i + j + k) % 6] ^ 32'h5A5A_A5A5,
                                           sg[0], sg[1], owc, zwc);

        in_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R2 final drain", {31'b0, out_valid}, 32'd0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule